// File: doc/BRIEF.md
# Seven-function 16-bit ALU

This block is a purely combinational arithmetic/logic unit for a small 16-bit datapath. Two 16-bit operands and a 3-bit operation code enter. One 16-bit result leaves within the same evaluation, with no clock or stored state. The unit adds and subtracts with modulo-2^16 wraparound. It forms bitwise AND, OR and the complement of the second operand. It also shifts the first operand left or right by a distance taken from the low nibble of the second operand.

The operation code encoding belongs to this block, and the control decoder that drives it must use the encoding listed below. There are no flag, carry or overflow outputs. Code 111 is reserved and yields zero.

Top module: `alu_core`

## Requirements
- R1: With op_i = 3'b000 the result is (a_i + b_i) mod 2^16; a carry out of bit 15 is dropped.
- R2: With op_i = 3'b001 the result is (a_i - b_i) mod 2^16; a borrow wraps around.
- R3: With op_i = 3'b010 the result is the bitwise AND of a_i and b_i.
- R4: With op_i = 3'b011 the result is the bitwise OR of a_i and b_i.
- R5: With op_i = 3'b100 the result is the bitwise complement of b_i, and a_i has no effect on it.
- R6: With op_i = 3'b101 the result is a_i shifted left by b_i[3:0], and the vacated low bits are zero.
- R7: With op_i = 3'b110 the result is a_i shifted right by b_i[3:0], and the vacated high bits are zero (a logical shift with no sign fill).
- R8: For both shifts, b_i[15:4] has no effect on the result.
- R9: A shift distance of zero returns a_i unchanged.
- R10: The reserved code op_i = 3'b111 returns zero for any operands.
- R11: The result follows any input change without a clock edge, and the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; the value that is shifted |
| b_i | input | 16 | Second operand; bits 3..0 give the shift distance |
| op_i | input | 3 | Operation code (see R1 to R10) |
| res_o | output | 16 | Result |

## Verification
Two functions can meet in a single evaluation. One is the masking of the upper B bits during a shift. The other is the zero-distance pass-through. They coincide when b_i has its upper twelve bits set and a zero low nibble. Directed vectors such as b_i = 16'hFFF0 provoke this, and the bench judges them by requiring res_o to equal a_i exactly for both shift codes. Random operands with all ones in b_i[15:4] are also mixed into the shift traffic, so that masking is exercised at every distance.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_NOT = 3'b100,
    OP_SHL = 3'b101,
    OP_SHR = 3'b110,
    OP_RSV = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
// Shared adder: subtraction is A + ~B + 1.
module alu_arith #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] b_x;

  assign b_x   = b_i ^ {WIDTH{sub_i}};
  assign res_o = a_i + b_x + WIDTH'(sub_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      // R1 R2
      arith_inverse_chk: assert (sub_i ? (res_o + b_i == a_i) : (res_o - b_i == a_i))
        else $error("arith_inverse_chk");
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] not_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign not_o = ~b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R3 R4
      and_or_order_chk: assert ((and_o & ~or_o) == '0)
        else $error("and_or_order_chk");
      // R5
      not_disjoint_chk: assert ((not_o & b_i) == '0 && (not_o | b_i) == '1)
        else $error("not_disjoint_chk");
    end
  end
endmodule

// File: rtl/alu_shift.sv
// Logarithmic barrel shifter, zero fill; LEFT picks the direction.
module alu_shift #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SHAMT_W = $clog2(WIDTH),
  parameter bit          LEFT    = 1'b1
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [WIDTH-1:0]   res_o
);
  logic [WIDTH-1:0] stage [SHAMT_W+1];

  assign stage[0] = a_i;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    if (LEFT) begin : g_l
      assign stage[s+1] = amt_i[s] ? (stage[s] << (2**s)) : stage[s];
    end else begin : g_r
      assign stage[s+1] = amt_i[s] ? (stage[s] >> (2**s)) : stage[s];
    end
  end

  assign res_o = stage[SHAMT_W];

  always_comb begin
    if (!$isunknown({a_i, amt_i})) begin
      // R9
      shift_zero_chk: assert (amt_i != '0 || res_o == a_i)
        else $error("shift_zero_chk");
      // R6 R7
      shift_fill_chk: assert ($countones(res_o) <= $countones(a_i))
        else $error("shift_fill_chk");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned SHAMT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] arith_res, and_res, or_res, not_res, shl_res, shr_res;
  logic [SHAMT_W-1:0] shamt;

  assign shamt = b_i[SHAMT_W-1:0];

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i(a_i), .b_i(b_i), .sub_i(op_i == OP_SUB), .res_o(arith_res)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .and_o(and_res), .or_o(or_res), .not_o(not_res)
  );

  alu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_shl (
    .a_i(a_i), .amt_i(shamt), .res_o(shl_res)
  );

  alu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_shr (
    .a_i(a_i), .amt_i(shamt), .res_o(shr_res)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: res_o = arith_res;
      OP_AND:         res_o = and_res;
      OP_OR:          res_o = or_res;
      OP_NOT:         res_o = not_res;
      OP_SHL:         res_o = shl_res;
      OP_SHR:         res_o = shr_res;
      default:        res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      // R10
      rsv_zero_chk: assert (op_i != OP_RSV || res_o == '0)
        else $error("rsv_zero_chk");
      // R5
      not_port_chk: assert (op_i != OP_NOT || (res_o ^ b_i) == '1)
        else $error("not_port_chk");
      // R7
      shr_msb_chk: assert (op_i != OP_SHR || shamt == '0 || !res_o[WIDTH-1])
        else $error("shr_msb_chk");
    end
  end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
  logic        clk = 1'b0;
  logic [15:0] a, b, res;
  logic [2:0]  op;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu_core u_dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res));

  function automatic logic [15:0] model(logic [2:0] o, logic [15:0] x, logic [15:0] y);
    case (o)
      3'b000:  return x + y;
      3'b001:  return x - y;
      3'b010:  return x & y;
      3'b011:  return x | y;
      3'b100:  return ~y;
      3'b101:  return x << y[3:0];
      3'b110:  return x >> y[3:0];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R6";
      3'b110:  return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, res, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [15:0] x, logic [15:0] y, string tag);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    check(tag, model(o, x, y));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] first;
    void'($urandom(32'd20240611));
    op = 3'b000; a = '0; b = '0;
    #1;
    // idle state: all-zero inputs give zero
    check("R1", 16'h0000);

    apply(3'b000, 16'hFFFF, 16'h0001, "R1");
    apply(3'b000, 16'h8000, 16'h8000, "R1");
    apply(3'b001, 16'h0000, 16'h0001, "R2");
    apply(3'b001, 16'h1234, 16'h1234, "R2");
    apply(3'b010, 16'hF0F0, 16'h3C3C, "R3");
    apply(3'b011, 16'hF0F0, 16'h0F0F, "R4");
    apply(3'b100, 16'h0000, 16'h00FF, "R5");
    apply(3'b100, 16'hFFFF, 16'h00FF, "R5");
    apply(3'b101, 16'h0001, 16'h000F, "R6");
    apply(3'b101, 16'hFFFF, 16'h0004, "R6");
    apply(3'b110, 16'h8000, 16'h000F, "R7");
    apply(3'b110, 16'hFFFF, 16'h0001, "R7");
    apply(3'b101, 16'h00A5, 16'hFFF3, "R8");
    apply(3'b110, 16'hA500, 16'h1233, "R8");
    apply(3'b101, 16'hBEEF, 16'hFFF0, "R9");
    apply(3'b110, 16'hBEEF, 16'hFFF0, "R9");
    apply(3'b110, 16'h8001, 16'h0000, "R9");
    apply(3'b111, 16'hFFFF, 16'hFFFF, "R10");
    apply(3'b111, 16'h1234, 16'h5678, "R10");

    // R5: A must not matter; compare two results with different A
    @(negedge clk);
    op = 3'b100; a = 16'h0000; b = 16'h5A5A; #1;
    first = res;
    a = 16'hFFFF; #1;
    checks++;
    if (res !== first) begin
      fails++;
      $display("FAIL R5 a-sensitivity actual=%h expected=%h", res, first);
    end

    // R11: result follows inputs between clock edges
    @(posedge clk);
    #0.5;
    op = 3'b000; a = 16'h0102; b = 16'h0304; #0.5;
    check("R11", 16'h0406);
    a = 16'h1000; #0.5;
    check("R11", 16'h1304);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0]  o;
      logic [15:0] x, y;
      o = 3'($urandom_range(0, 7));
      x = 16'($urandom);
      y = 16'($urandom);
      if ((o == 3'b101 || o == 3'b110) && (i % 3 == 0)) y[15:4] = 12'hFFF;
      apply(o, x, y, tag_of(o));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule